// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Array

This block holds the waiting operations for one class of functional unit, such as a floating-point adder. When an operation is issued, one free slot captures the operation code and two source operands. A source arrives either as a value that is already known or as the nonzero tag of the station that will produce it. A tag of zero marks a source as ready. Each slot owns a fixed nonzero tag, and that tag names the slot's result to the rest of the machine.

Every cycle, all busy slots compare the single result broadcast bus against their pending source tags. On a match they take the 64-bit value and clear the tag. A slot whose two tags are both zero may be sent to its execution unit, and only while that unit reports idle. If several slots are ready, the one issued earliest goes first. A slot stays occupied after it is sent and is released only when a result carrying its own tag appears on the bus. When every slot is occupied, the issue side sees a stall and any issue attempt is dropped.

Top module: `rs_array`

## Requirements
- R1: After reset no slot is occupied: `issue_stall` is 0, `disp_valid` is 0 and `issue_tag` is 1.
- R2: An issue is accepted into the lowest-numbered free slot, and `issue_tag` shows that slot's tag (slot i has tag 1+i, so 1, 2, 3 with three slots). `issue_stall` is 1 exactly when all slots are occupied, and an issue made while it is 1 is dropped and never dispatched.
- R3: A slot issued with both source tags zero is presented on `disp_valid`/`disp_op`/`disp_vj`/`disp_vk`/`disp_tag` in the cycle after issue, carrying the issued values, provided `unit_idle` is 1.
- R4: `disp_valid` is 1 only while `unit_idle` is 1. A ready slot is held until the unit becomes idle.
- R5: A busy slot whose source tag equals `bus_tag` while `bus_valid` is 1 replaces that operand with `bus_data` and clears the tag. It becomes eligible once both tags are clear.
- R6: If a source's producer broadcasts in the same cycle that the slot is issued, the slot captures `bus_data` for that source rather than keeping the tag.
- R7: Among ready slots, the one issued earliest is dispatched first, regardless of slot number.
- R8: A busy slot is released when `bus_valid` is 1 with `bus_tag` equal to its own tag. A full array then drops its stall and offers that slot's tag for the next issue.
- R9: A slot is dispatched at most once per occupancy. It is not presented again while it waits for its result.
- R10: A broadcast whose tag matches no pending source leaves a waiting slot not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An operation is offered for issue this cycle |
| issue_op | input | OP_W | Operation code of the offered operation |
| issue_vj | input | DATA_W | First source value, used when its tag is zero |
| issue_qj | input | TAG_W | Producer tag of the first source, zero if ready |
| issue_vk | input | DATA_W | Second source value, used when its tag is zero |
| issue_qk | input | TAG_W | Producer tag of the second source, zero if ready |
| issue_stall | output | 1 | All slots occupied; issue is refused |
| issue_tag | output | TAG_W | Tag of the slot the next accepted issue will use |
| bus_valid | input | 1 | A result is on the broadcast bus |
| bus_tag | input | TAG_W | Tag of the station that produced the broadcast result |
| bus_data | input | DATA_W | Broadcast result value |
| unit_idle | input | 1 | Execution unit can accept an operation this cycle |
| disp_valid | output | 1 | An operation is handed to the execution unit |
| disp_op | output | OP_W | Operation code of the dispatched slot |
| disp_vj | output | DATA_W | First operand of the dispatched slot |
| disp_vk | output | DATA_W | Second operand of the dispatched slot |
| disp_tag | output | TAG_W | Tag of the dispatched slot |

## Verification
The capture path is swept over all four combinations of ready and pending sources. Each combination is run once with the producers broadcasting only after issue and once with one producer broadcasting in the issue cycle itself. Comparing the two runs shows whether a same-cycle result is taken or lost behind a stale tag. Each run also sends an unrelated tag first, which separates exact tag matching from loose matching. A fill, free and refill sequence leaves the slot numbers out of age order. That exposes pickers that favour a slot index over issue age, and it also shows whether a refused issue leaks into the array.

// File: rtl/rs_pkg.sv
// Shared helpers for the reservation station array.
// Assumes: counts passed to idx_w are at least 1.
package rs_pkg;
    // Index width for a count of items, at least one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rs_entry.sv
// One reservation slot: holds an operation and two operands, snoops the
// result bus for pending producer tags, and tracks whether it was sent.
// Assumes: alloc is only raised while the slot is free; tag 0 means ready.
module rs_entry #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4,
    parameter int OP_W   = 2,
    parameter int MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_vj,
    input  logic [TAG_W-1:0]  in_qj,
    input  logic [DATA_W-1:0] in_vk,
    input  logic [TAG_W-1:0]  in_qk,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              grant,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk,
    output logic [TAG_W-1:0]  qj,
    output logic [TAG_W-1:0]  qk
);
    localparam logic [TAG_W-1:0] SELF = TAG_W'(MY_TAG);

    logic sent;
    logic hit_in_j, hit_in_k, hit_j, hit_k, hit_self;

    // Tag comparators for the issue inputs and the stored tags.
    always_comb begin
        hit_in_j = bus_valid && (in_qj != '0) && (bus_tag == in_qj);
        hit_in_k = bus_valid && (in_qk != '0) && (bus_tag == in_qk);
        hit_j    = bus_valid && (qj != '0) && (bus_tag == qj);
        hit_k    = bus_valid && (qk != '0) && (bus_tag == qk);
        hit_self = bus_valid && (bus_tag == SELF);
    end

    // Slot state: capture on issue, snoop while busy, release on own result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sent <= 1'b0;
            op   <= '0;
            vj   <= '0;
            vk   <= '0;
            qj   <= '0;
            qk   <= '0;
        end else if (alloc) begin
            busy <= 1'b1;
            sent <= 1'b0;
            op   <= in_op;
            vj   <= hit_in_j ? bus_data : in_vj;
            qj   <= hit_in_j ? '0 : in_qj;
            vk   <= hit_in_k ? bus_data : in_vk;
            qk   <= hit_in_k ? '0 : in_qk;
        end else if (busy) begin
            if (hit_j) begin
                vj <= bus_data;
                qj <= '0;
            end
            if (hit_k) begin
                vk <= bus_data;
                qk <= '0;
            end
            if (grant)
                sent <= 1'b1;
            if (hit_self) begin
                busy <= 1'b0;
                sent <= 1'b0;
            end
        end
    end

    // Eligible: occupied, not yet sent, both operands present.
    assign ready = busy && !sent && (qj == '0) && (qk == '0);
endmodule

// File: rtl/rs_alloc.sv
// Free-slot finder: picks the lowest-numbered free slot.
// Assumes: N >= 1; outputs are don't-care for issue when none is free.
module rs_alloc #(
    parameter int N     = 3,
    parameter int IDX_W = rs_pkg::idx_w(N)
) (
    input  logic [N-1:0]     busy,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx,
    output logic [N-1:0]     free_pick
);
    // Scan from the top so the lowest free index wins.
    always_comb begin
        free_idx  = '0;
        free_pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_idx  = IDX_W'(i);
                free_pick = '0;
                free_pick[i] = 1'b1;
            end
        end
        any_free = !(&busy);
    end
endmodule

// File: rtl/rs_age_pick.sv
// Age matrix and oldest-ready picker. older[i][j] set means slot i was
// issued before slot j and both were occupied at j's issue.
// Assumes: at most one bit of alloc_vec is set per cycle.
module rs_age_pick #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_vec,
    input  logic [N-1:0] busy,
    input  logic [N-1:0] ready,
    output logic [N-1:0] pick
);
    logic [N-1:0] older [N];
    logic [N-1:0] blocked;

    // Update row and column of a newly issued slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++)
                older[i] <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (alloc_vec[k]) begin
                    for (int j = 0; j < N; j++) begin
                        if (j != k) begin
                            older[j][k] <= busy[j];
                            older[k][j] <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    // A ready slot is picked when no older slot is also ready.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < N; j++) begin
                if ((j != i) && ready[j] && older[j][i])
                    blocked[i] = 1'b1;
            end
            pick[i] = ready[i] && !blocked[i];
        end
    end
endmodule

// File: rtl/rs_array.sv
// Reservation station array for one functional-unit class. Issues into the
// lowest free slot, snoops one result bus, dispatches the oldest ready slot
// while the unit is idle, and frees a slot when its own tag is broadcast.
// Assumes: slot tags TAG_BASE..TAG_BASE+N_ENT-1 are nonzero and fit TAG_W.
module rs_array #(
    parameter int N_ENT    = 3,
    parameter int DATA_W   = 64,
    parameter int TAG_W    = 4,
    parameter int OP_W     = 2,
    parameter int TAG_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [OP_W-1:0]   issue_op,
    input  logic [DATA_W-1:0] issue_vj,
    input  logic [TAG_W-1:0]  issue_qj,
    input  logic [DATA_W-1:0] issue_vk,
    input  logic [TAG_W-1:0]  issue_qk,
    output logic              issue_stall,
    output logic [TAG_W-1:0]  issue_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              unit_idle,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_vj,
    output logic [DATA_W-1:0] disp_vk,
    output logic [TAG_W-1:0]  disp_tag
);
    localparam int IDX_W = rs_pkg::idx_w(N_ENT);

    logic [N_ENT-1:0]       ent_busy, ent_ready, alloc_vec, free_pick, pick, grant;
    logic                   any_free, do_issue;
    logic [IDX_W-1:0]       free_idx;
    logic [OP_W-1:0]        e_op [N_ENT];
    logic [DATA_W-1:0]      e_vj [N_ENT];
    logic [DATA_W-1:0]      e_vk [N_ENT];
    logic [N_ENT*TAG_W-1:0] ent_qj_flat, ent_qk_flat;

    rs_alloc #(.N(N_ENT), .IDX_W(IDX_W)) u_alloc (
        .busy(ent_busy), .any_free(any_free),
        .free_idx(free_idx), .free_pick(free_pick)
    );

    // Issue acceptance and slot selection.
    always_comb begin
        do_issue    = issue_valid && any_free;
        alloc_vec   = do_issue ? free_pick : '0;
        issue_stall = !any_free;
        issue_tag   = TAG_W'(TAG_BASE) + TAG_W'(free_idx);
    end

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_slot
            rs_entry #(
                .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W),
                .MY_TAG(TAG_BASE + g)
            ) u_ent (
                .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[g]),
                .in_op(issue_op), .in_vj(issue_vj), .in_qj(issue_qj),
                .in_vk(issue_vk), .in_qk(issue_qk),
                .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
                .grant(grant[g]), .busy(ent_busy[g]), .ready(ent_ready[g]),
                .op(e_op[g]), .vj(e_vj[g]), .vk(e_vk[g]),
                .qj(ent_qj_flat[g*TAG_W +: TAG_W]),
                .qk(ent_qk_flat[g*TAG_W +: TAG_W])
            );
        end
    endgenerate

    rs_age_pick #(.N(N_ENT)) u_pick (
        .clk(clk), .rst_n(rst_n), .alloc_vec(alloc_vec),
        .busy(ent_busy), .ready(ent_ready), .pick(pick)
    );

    // Dispatch gating and one-hot output mux.
    always_comb begin
        grant      = unit_idle ? pick : '0;
        disp_valid = |grant;
        disp_op    = '0;
        disp_vj    = '0;
        disp_vk    = '0;
        disp_tag   = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (grant[i]) begin
                disp_op  = disp_op | e_op[i];
                disp_vj  = disp_vj | e_vj[i];
                disp_vk  = disp_vk | e_vk[i];
                disp_tag = disp_tag | (TAG_W'(TAG_BASE) + TAG_W'(i));
            end
        end
    end
endmodule

// File: rtl/rs_array_chk.sv
// Property checker for rs_array, attached by bind. Watches ports plus the
// per-slot busy flags and stored producer tags.
// Assumes: same parameters as the bound array.
module rs_array_chk #(
    parameter int N_ENT    = 3,
    parameter int TAG_W    = 4,
    parameter int TAG_BASE = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   issue_stall,
    input logic [TAG_W-1:0]       issue_tag,
    input logic                   bus_valid,
    input logic [TAG_W-1:0]       bus_tag,
    input logic                   unit_idle,
    input logic                   disp_valid,
    input logic [TAG_W-1:0]       disp_tag,
    input logic [N_ENT-1:0]       ent_busy,
    input logic [N_ENT*TAG_W-1:0] ent_qj_flat,
    input logic [N_ENT*TAG_W-1:0] ent_qk_flat
);
    localparam int TAG_TOP = TAG_BASE + N_ENT - 1;

    assert_disp_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> unit_idle);

    assert_disp_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (int'(disp_tag) >= TAG_BASE && int'(disp_tag) <= TAG_TOP));

    assert_issue_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_stall |-> (int'(issue_tag) >= TAG_BASE && int'(issue_tag) <= TAG_TOP));

    assert_no_redispatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !(disp_valid && disp_tag == $past(disp_tag)));

    assert_free_unstall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && issue_stall && int'(bus_tag) >= TAG_BASE && int'(bus_tag) <= TAG_TOP)
        |=> !issue_stall);

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_cap
            // R5 and R6: no occupied slot keeps a tag that was just broadcast.
            assert_bus_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_valid && bus_tag != '0) |=>
                (!ent_busy[g] ||
                 (ent_qj_flat[g*TAG_W +: TAG_W] != $past(bus_tag) &&
                  ent_qk_flat[g*TAG_W +: TAG_W] != $past(bus_tag))));
        end
    endgenerate
endmodule

bind rs_array rs_array_chk #(.N_ENT(N_ENT), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_stall(issue_stall), .issue_tag(issue_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .unit_idle(unit_idle),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .ent_busy(ent_busy),
    .ent_qj_flat(ent_qj_flat), .ent_qk_flat(ent_qk_flat)
);

// File: tb/tb_rs_array.sv
// Self-checking bench for rs_array with three slots (tags 1..3).
module tb_rs_array;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] D8 = 64'hD8D8_0000_1234_0008;
    localparam logic [63:0] D9 = 64'hD9D9_0000_5678_0009;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [1:0]  issue_op = '0;
    logic [63:0] issue_vj = '0, issue_vk = '0;
    logic [3:0]  issue_qj = '0, issue_qk = '0;
    logic        issue_stall;
    logic [3:0]  issue_tag;
    logic        bus_valid = 1'b0;
    logic [3:0]  bus_tag = '0;
    logic [63:0] bus_data = '0;
    logic        unit_idle = 1'b0;
    logic        disp_valid;
    logic [1:0]  disp_op;
    logic [63:0] disp_vj, disp_vk;
    logic [3:0]  disp_tag;

    int checks = 0;
    int errors = 0;

    rs_array dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_vj(issue_vj), .issue_qj(issue_qj), .issue_vk(issue_vk), .issue_qk(issue_qk),
        .issue_stall(issue_stall), .issue_tag(issue_tag), .bus_valid(bus_valid),
        .bus_tag(bus_tag), .bus_data(bus_data), .unit_idle(unit_idle),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_vj(disp_vj),
        .disp_vk(disp_vk), .disp_tag(disp_tag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_issue(input logic [1:0] op, input logic [63:0] vj, input logic [3:0] qj,
                               input logic [63:0] vk, input logic [3:0] qk);
        issue_valid = 1'b1; issue_op = op;
        issue_vj = vj; issue_qj = qj; issue_vk = vk; issue_qk = qk;
    endtask

    task automatic drive_bus(input logic [3:0] t, input logic [63:0] d);
        bus_valid = 1'b1; bus_tag = t; bus_data = d;
    endtask

    task automatic idle_inputs();
        issue_valid = 1'b0; bus_valid = 1'b0; bus_tag = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "stall", 64'(issue_stall), 64'd0);
        chk("R1", "disp_valid", 64'(disp_valid), 64'd0);
        chk("R1", "issue_tag", 64'(issue_tag), 64'd1);

        // R4: ready slot held while unit busy
        @(negedge clk);
        unit_idle = 1'b0;
        drive_issue(2'd1, 64'h55, 4'd0, 64'h66, 4'd0);
        @(negedge clk); idle_inputs();
        chk("R4", "held cycle1", 64'(disp_valid), 64'd0);
        @(negedge clk);
        chk("R4", "held cycle2", 64'(disp_valid), 64'd0);
        unit_idle = 1'b1; #1;
        chk("R4", "released", 64'(disp_valid), 64'd1);
        chk("R4", "vj", disp_vj, 64'h55);
        @(negedge clk);
        drive_bus(4'd1, 64'h0);
        @(negedge clk); idle_inputs();

        // Sweep: sources ready/pending x broadcast timing
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 2; m++) begin
                logic pend_j, pend_k;
                logic [63:0] a, b, ej, ek;
                a = 64'h1111_0000_0000_0000 | 64'(p * 16 + m);
                b = 64'h2222_0000_0000_0000 | 64'(p * 16 + m);
                ej = p[0] ? D8 : a;
                ek = p[1] ? D9 : b;
                pend_j = p[0] && (m == 0);
                pend_k = p[1] && !((m == 1) && !p[0]);
                unit_idle = 1'b1;
                drive_issue(2'(p), a, p[0] ? 4'd8 : 4'd0, b, p[1] ? 4'd9 : 4'd0);
                #1 chk("R2", "sweep issue_tag", 64'(issue_tag), 64'd1);
                if (m == 1 && p[0]) drive_bus(4'd8, D8);
                else if (m == 1 && p[1]) drive_bus(4'd9, D9);
                @(negedge clk); idle_inputs();
                if (pend_j || pend_k) begin
                    chk("R5", "waiting not ready", 64'(disp_valid), 64'd0);
                    drive_bus(4'd12, 64'hBAD);
                    @(negedge clk); idle_inputs();
                    chk("R10", "unrelated tag", 64'(disp_valid), 64'd0);
                    if (pend_j) begin
                        drive_bus(4'd8, D8);
                        @(negedge clk); idle_inputs();
                    end
                    if (pend_k) begin
                        drive_bus(4'd9, D9);
                        @(negedge clk); idle_inputs();
                    end
                end
                chk((m == 1 && p != 0) ? "R6" : (p == 0 ? "R3" : "R5"), "disp_valid",
                    64'(disp_valid), 64'd1);
                chk("R3", "disp_tag", 64'(disp_tag), 64'd1);
                chk("R3", "disp_op", 64'(disp_op), 64'(p));
                chk((m == 1 && p[0]) ? "R6" : "R5", "disp_vj", disp_vj, ej);
                chk((m == 1 && p == 2) ? "R6" : "R5", "disp_vk", disp_vk, ek);
                @(negedge clk);
                chk("R9", "no second dispatch", 64'(disp_valid), 64'd0);
                drive_bus(4'd1, 64'h0);
                @(negedge clk); idle_inputs();
            end
        end

        // Fill, stall, free, refill, age order
        unit_idle = 1'b0;
        for (int s = 0; s < 3; s++) begin
            drive_issue(2'(s), 64'h100 + 64'(s), 4'd8, 64'h200 + 64'(s), 4'd0);
            #1 chk("R2", "fill issue_tag", 64'(issue_tag), 64'(s + 1));
            @(negedge clk); idle_inputs();
        end
        chk("R2", "full stall", 64'(issue_stall), 64'd1);
        drive_issue(2'd3, 64'hEEE, 4'd0, 64'hFFF, 4'd0);
        @(negedge clk); idle_inputs();
        chk("R2", "still stalled", 64'(issue_stall), 64'd1);
        drive_bus(4'd2, 64'h0);
        @(negedge clk); idle_inputs();
        chk("R8", "freed stall", 64'(issue_stall), 64'd0);
        chk("R8", "freed tag reused", 64'(issue_tag), 64'd2);
        drive_issue(2'd2, 64'h77, 4'd0, 64'h88, 4'd0);
        @(negedge clk); idle_inputs();
        drive_bus(4'd8, D8);
        @(negedge clk); idle_inputs();
        unit_idle = 1'b1; #1;
        chk("R7", "oldest first", 64'(disp_tag), 64'd1);
        chk("R7", "oldest op", 64'(disp_op), 64'd0);
        @(negedge clk);
        chk("R7", "second oldest", 64'(disp_tag), 64'd3);
        chk("R5", "second vj", disp_vj, D8);
        @(negedge clk);
        chk("R7", "newest last", 64'(disp_tag), 64'd2);
        chk("R7", "newest op", 64'(disp_op), 64'd2);
        @(negedge clk);
        chk("R2", "refused issue absent", 64'(disp_valid), 64'd0);
        for (int t = 1; t <= 3; t++) begin
            drive_bus(4'(t), 64'h0);
            @(negedge clk); idle_inputs();
        end
        chk("R8", "all freed stall", 64'(issue_stall), 64'd0);
        chk("R8", "all freed tag", 64'(issue_tag), 64'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule